// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock of a PCM serial audio port when the port is the timing master. Both clocks come from an oversampled master clock, and the block runs entirely in that clock's domain. An 8-bit control register selects how many master clock cycles form one sample frame. It does this with a 2-bit ratio code and a doubling bit. The register also carries an automatic-rate-detection enable, which only makes sense when the port is a slave.

Each frame has a fixed number of bit clock periods: two slots of `SLOT_BITS` bits, 64 bits by default. One bit period therefore lasts ratio/64 master cycles, and that can be an odd count such as 3. A finite-state machine with three states controls the counters:
- `ST_IDLE`: outputs low.
- `ST_LOAD`: one cycle in which the new setting is latched and the counters are cleared.
- `ST_RUN`: the clocks toggle.

The transitions are:
- `ST_IDLE`→`ST_LOAD`: master mode is on with a usable setting.
- `ST_LOAD`→`ST_RUN`: always, after one cycle.
- `ST_RUN`→`ST_LOAD`: the ratio fields changed. This is taken only on the last cycle of a bit period.
- `ST_RUN`→`ST_IDLE`: the setting became unusable or the port left master mode. This is also taken only on the last cycle of a bit period.

Because these exits wait for the end of a bit period, a high phase of the bit clock is never cut short.

Top module: `audio_sclk_gen`

## Requirements
- R1: With the doubling bit at 0, ratio code 3 gives 384, code 2 gives 256, code 1 gives 192 and code 0 gives 128 master cycles per frame. One bit period lasts ratio/64 master cycles.
- R2: With the doubling bit at 1, each code gives twice its base ratio (768, 512, 384, 256), and the bit period doubles with it.
- R3: Control register fields:
  - bit 7 is automatic detection;
  - bits 6:5 are the ratio code;
  - bit 4 is the doubling bit;
  - bits 3:0 have no effect on any output.
- R4: Within each bit period of D cycles, the bit clock is low for ceil(D/2) cycles and then high for floor(D/2) cycles. For D=3 this means low for 2 cycles and high for 1.
- R5: The frame clock is low for the first 32 bit periods of a frame (left slot) and high for the next 32 (right slot). It changes only in the cycle where the bit clock falls.
- R6: After reset, bit clock, frame clock and error flag are low. When a usable master setting is applied from idle, the outputs stay low for two more cycles, and the first left-slot bit period then starts on the second clock edge after the setting is applied.
- R7: When the ratio code or doubling bit changes while running, the current bit period completes. The outputs are then low for one cycle, and the new frame starts at the beginning of a left slot.
- R8: In slave mode (`master_mode`=0), the control register is ignored and the error flag is low. Both clocks go low at the end of the current bit period and stay low.
- R9: The error flag is high whenever master mode is on and automatic detection (bit 7) is set. The clocks stop as in R8.
- R10: The error flag is also high in master mode when the ratio is not a multiple of the frame bit count, or gives fewer than 2 cycles per bit. With 128-bit frames, this applies to codes 0 and 1 with the doubling bit at 0. The clocks stop as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = this port generates the serial clocks |
| ctrl_reg | input | 8 | Control register: [7] auto detect, [6:5] ratio code, [4] doubling, [3:0] unused |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock, low = left slot, high = right slot |
| cfg_err | output | 1 | Unsupported master configuration |

## Verification
The delicate collision is a configuration change landing on the last master cycle of a frame. At that edge the end of the bit period, the right-to-left frame clock transition and the restart through `ST_LOAD` all happen together. The bench provokes this by holding the first 384-fs setting for exactly enough cycles that the new code is presented while the model sits on the final phase of bit 63. A reference model written from the requirements predicts every output cycle by cycle. It expects the frame clock to fall together with the bit clock, followed by a single low cycle and a clean left slot at the new period. Any stretched or shortened phase shows as a mismatch in the scoreboard.

// File: rtl/asg_pkg.sv
package asg_pkg;

    localparam int unsigned RATIO_MAX = 768;
    localparam int unsigned CTRL_W    = 8;
    localparam int unsigned AUTO_POS  = 7;
    localparam int unsigned CODE_POS  = 5;
    localparam int unsigned DBL_POS   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } asg_state_e;

    typedef struct packed {
        logic [1:0] code;
        logic       dbl;
    } asg_cfg_t;

    function automatic logic [9:0] base_ratio(input logic [1:0] code);
        logic [9:0] r;
        unique case (code)
            2'b11:   r = 10'd384;
            2'b10:   r = 10'd256;
            2'b01:   r = 10'd192;
            default: r = 10'd128;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/asg_cfg_decode.sv
module asg_cfg_decode
    import asg_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 64,
    parameter int unsigned PH_W       = 10
) (
    input  logic            master_mode,
    input  logic            auto_en,
    input  logic [1:0]      code,
    input  logic            dbl,
    output asg_cfg_t        cfg,
    output logic [PH_W-1:0] div,
    output logic            cfg_err,
    output logic            cfg_ok
);

    logic unsup;

    always_comb begin
        int unsigned ratio;
        int unsigned per_bit;
        ratio = {22'd0, base_ratio(code)};
        if (dbl) begin
            ratio = ratio << 1;
        end
        per_bit = ratio / FRAME_BITS;
        unsup   = ((ratio % FRAME_BITS) != 0) || (per_bit < 2);
        div     = PH_W'(per_bit);
    end

    assign cfg.code = code;
    assign cfg.dbl  = dbl;
    assign cfg_err  = master_mode && (auto_en || unsup);
    assign cfg_ok   = master_mode && !auto_en && !unsup;

endmodule

// File: rtl/asg_bit_timer.sv
module asg_bit_timer #(
    parameter int unsigned PH_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            advance,
    input  logic [PH_W-1:0] div,
    output logic            bit_end,
    output logic            bclk_hi
);

    logic [PH_W-1:0] ph;
    logic [PH_W:0]   lo_len;

    assign bit_end = (ph == div - 1'b1);
    assign lo_len  = ({1'b0, div} + 1'b1) >> 1;
    assign bclk_hi = ({1'b0, ph} >= lo_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (clear) begin
            ph <= '0;
        end else if (advance) begin
            ph <= bit_end ? '0 : ph + 1'b1;
        end
    end

endmodule

// File: rtl/asg_frame_counter.sv
module asg_frame_counter #(
    parameter int unsigned FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic right_slot
);

    localparam int unsigned BW   = $clog2(FRAME_BITS);
    localparam int unsigned HALF = FRAME_BITS / 2;

    logic [BW-1:0] idx;

    assign right_slot = (idx >= BW'(HALF));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= (idx == BW'(FRAME_BITS - 1)) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/audio_sclk_gen.sv
module audio_sclk_gen
    import asg_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic [CTRL_W-1:0] ctrl_reg,
    output logic              bclk,
    output logic              fclk,
    output logic              cfg_err
);

    localparam int unsigned FRAME_BITS = 2 * SLOT_BITS;
    localparam int unsigned PH_W       = $clog2(RATIO_MAX + 1);

    asg_state_e      st, st_nxt;
    asg_cfg_t        cfg_new, cfg_q;
    logic [PH_W-1:0] div_new, div_q;
    logic            cfg_ok;
    logic            bit_end, bclk_hi, right_slot;
    logic            running;
    logic            unused_low;

    assign unused_low = ^ctrl_reg[DBL_POS-1:0];
    assign running    = (st == ST_RUN);

    asg_cfg_decode #(
        .FRAME_BITS (FRAME_BITS),
        .PH_W       (PH_W)
    ) u_decode (
        .master_mode (master_mode),
        .auto_en     (ctrl_reg[AUTO_POS]),
        .code        (ctrl_reg[CODE_POS+1:CODE_POS]),
        .dbl         (ctrl_reg[DBL_POS]),
        .cfg         (cfg_new),
        .div         (div_new),
        .cfg_err     (cfg_err),
        .cfg_ok      (cfg_ok)
    );

    asg_bit_timer #(
        .PH_W (PH_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!running),
        .advance (running),
        .div     (div_q),
        .bit_end (bit_end),
        .bclk_hi (bclk_hi)
    );

    asg_frame_counter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!running),
        .step       (running && bit_end),
        .right_slot (right_slot)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Setting captured during the load cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            div_q <= PH_W'(2);
        end else if (st == ST_LOAD) begin
            cfg_q <= cfg_new;
            div_q <= div_new;
        end
    end

    // Transitions: exits from ST_RUN only on the last cycle of a bit
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (cfg_ok) st_nxt = ST_LOAD;
            ST_LOAD: st_nxt = ST_RUN;
            ST_RUN: begin
                if (bit_end) begin
                    if (!cfg_ok) begin
                        st_nxt = ST_IDLE;
                    end else if (cfg_new != cfg_q) begin
                        st_nxt = ST_LOAD;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bclk = 1'b0;
        fclk = 1'b0;
        unique case (st)
            ST_RUN: begin
                bclk = bclk_hi;
                fclk = right_slot;
            end
            default: begin
                bclk = 1'b0;
                fclk = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/asg_checker.sv
module asg_checker #(
    parameter int unsigned PH_W        = 10,
    parameter int unsigned QUIET_LIMIT = 768
) (
    input logic            clk,
    input logic            rst_n,
    input logic            master_mode,
    input logic            cfg_err,
    input logic            bclk,
    input logic            fclk,
    input logic [PH_W-1:0] div_q
);

    logic [PH_W-1:0] hi_len;
    logic [PH_W:0]   quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
            quiet  <= '0;
        end else begin
            hi_len <= bclk ? hi_len + 1'b1 : '0;
            if (master_mode && !cfg_err) begin
                quiet <= '0;
            end else if (quiet <= (PH_W+1)'(QUIET_LIMIT)) begin
                quiet <= quiet + 1'b1;
            end
        end
    end

    AST_FCLK_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fclk) |-> $fell(bclk)); // R5

    AST_NO_RUNT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk) |-> (hi_len == (div_q >> 1))); // R7

    AST_SLAVE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> !cfg_err); // R8

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet > (PH_W+1)'(QUIET_LIMIT)) |-> (!bclk && !fclk)); // R9

endmodule

bind audio_sclk_gen asg_checker #(
    .PH_W        (PH_W),
    .QUIET_LIMIT (RATIO_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .cfg_err     (cfg_err),
    .bclk        (bclk),
    .fclk        (fclk),
    .div_q       (div_q)
);

// File: tb/tb_audio_sclk_gen.sv
`timescale 1ns/1ps
module tb_audio_sclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic       bclk, fclk, err;
    logic       master_w = 1'b0;
    logic [7:0] ctrl_w = 8'h00;
    logic       bclk_w, fclk_w, err_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic q_b[$];
    logic q_f[$];
    logic q_e[$];
    int   q_r[$];

    // reference model state: 0 idle, 1 load, 2 run
    int       m_st = 0;
    int       m_i  = 0;
    int       m_d  = 2;
    logic [2:0] m_cfg = 3'b000;

    always #2.5 clk = ~clk;

    audio_sclk_gen dut (
        .clk (clk), .rst_n (rst_n), .master_mode (master), .ctrl_reg (ctrl),
        .bclk (bclk), .fclk (fclk), .cfg_err (err)
    );

    audio_sclk_gen #(.SLOT_BITS(64)) dut_wide (
        .clk (clk), .rst_n (rst_n), .master_mode (master_w), .ctrl_reg (ctrl_w),
        .bclk (bclk_w), .fclk (fclk_w), .cfg_err (err_w)
    );

    function automatic int ratio_of(input logic [1:0] code, input logic dbl);
        int r;
        case (code)
            2'b11:   r = 384;
            2'b10:   r = 256;
            2'b01:   r = 192;
            default: r = 128;
        endcase
        return dbl ? 2 * r : r;
    endfunction

    task automatic check1(input int req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // emit expected outputs of the current cycle, then advance across one edge
    task automatic model_cycle(input logic [7:0] c, input logic m, input int tag);
        int   ratio, dn;
        logic e, v;
        ratio = ratio_of(c[6:5], c[4]);
        dn    = ratio / 64;
        e     = m && (c[7] || (ratio % 64 != 0) || dn < 2);
        v     = m && !e;
        q_b.push_back((m_st == 2) && ((m_i % m_d) >= (m_d + 1) / 2));
        q_f.push_back((m_st == 2) && (((m_i / m_d) % 64) >= 32));
        q_e.push_back(e);
        q_r.push_back(tag);
        case (m_st)
            0: if (v) m_st = 1;
            1: begin m_st = 2; m_i = 0; m_d = dn; m_cfg = c[6:4]; end
            default: begin
                if ((m_i % m_d) == m_d - 1) begin
                    if (!v) m_st = 0;
                    else if (c[6:4] != m_cfg) m_st = 1;
                    else m_i++;
                end else begin
                    m_i++;
                end
            end
        endcase
    endtask

    // driver: apply inputs and queue n cycles of expected outputs
    task automatic drive(input logic [7:0] c, input logic m, input int n, input int tag);
        @(posedge clk);
        #1;
        ctrl   = c;
        master = m;
        for (int k = 0; k < n; k++) model_cycle(c, m, tag);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (q_b.size() > 0) begin
                logic eb, ef, ee;
                int   r;
                eb = q_b.pop_front();
                ef = q_f.pop_front();
                ee = q_e.pop_front();
                r  = q_r.pop_front();
                checks++;
                if (bclk !== eb || fclk !== ef || err !== ee) begin
                    errors++;
                    $display("FAIL R%0d bclk/fclk/err actual=%b%b%b expected=%b%b%b",
                             r, bclk, fclk, err, eb, ef, ee);
                end
            end
        end
    end

    task automatic wide_case(input logic [7:0] c, input logic exp_err, input int req);
        @(posedge clk);
        #1;
        ctrl_w   = c;
        master_w = 1'b1;
        @(negedge clk);
        check1(req, "wide cfg_err", err_w, exp_err);
        repeat (40) @(negedge clk);
        if (exp_err) begin
            check1(req, "wide bclk stopped", bclk_w, 1'b0);
            check1(req, "wide fclk stopped", fclk_w, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        check1(6, "reset bclk", bclk, 1'b0);
        check1(6, "reset fclk", fclk, 1'b0);
        check1(6, "reset err", err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: slave mode ignores the register
        drive(8'h70, 1'b0, 20, 8);
        // R6/R1: start from idle at 384 fs, stop on the last cycle of frame 2
        drive(8'h60, 1'b1, 2 + 2 * 384 - 1, 6);
        // R7: change lands on last cycle of a frame, restart at 192 fs
        drive(8'h20, 1'b1, 2 * 192 + 11, 7);
        // R3: junk in bits 3:0, code 0 doubled (256 fs)
        drive(8'h1A, 1'b1, 2 * 256 + 5, 3);
        // R2: doubled code 2 (512 fs), doubled code 3 (768 fs)
        drive(8'h50, 1'b1, 520, 2);
        drive(8'h70, 1'b1, 2 * 768 + 9, 2);
        // R1: code 0 base (128 fs)
        drive(8'h00, 1'b1, 2 * 128 + 3, 1);
        // R9: auto-detect in master mode
        drive(8'hE0, 1'b1, 40, 9);
        // R4: odd bit period from idle (192 fs)
        drive(8'h20, 1'b1, 2 * 192 + 4, 4);
        // R8: leave master mode, then register changes while slave
        drive(8'h20, 1'b0, 30, 8);
        drive(8'h5F, 1'b0, 20, 8);
        // R5: slots at 256 fs, then R3 junk-bit change must not restart
        drive(8'h40, 1'b1, 2 * 256 + 2, 5);
        drive(8'h4F, 1'b1, 300, 3);

        // R10: 128-bit frames
        wide_case(8'h00, 1'b1, 10);
        wide_case(8'h20, 1'b1, 10);
        wide_case(8'h40, 1'b0, 10);
        wide_case(8'h10, 1'b0, 10);
        wide_case(8'h00, 1'b1, 10);
        wide_case(8'h60, 1'b0, 10);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule